// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller for a successive-approximation converter that sits behind an eight-input analog multiplexer. Software sets it up through a small register port. The setup covers single-ended or differential operation, the channel or pair to convert, the positive and negative reference sources, whether the external pins see the multiplexer output, a start delay, whether a pin trigger may start a conversion, and whether completion raises an interrupt.

A conversion starts from a command write or from a rising edge on the trigger pin. The block first counts the programmed delay in core clocks. It then holds the sample strobe for one cycle and runs one trial code per clock from the most significant bit down, keeping each bit that the external comparator accepts. When the last bit is settled the result is latched, done rises, busy falls and the block waits for the next start. Reading the result register clears done.

Top module: `adc_sar_seq`

## Requirements
- R1: With a comparator that reports 1 when the input is at or above the trial code, the latched result equals the input level for every level from 0 to 2^RES_W-1. RES_W defaults to 12.
- R2: The first trial code after the sample cycle has only the most significant bit set. Each later clock settles one lower bit.
- R3: After an accepted start with delay D, busy stays high for exactly D+1+RES_W cycles. Sample is high for exactly one of those cycles, the one D cycles after the start edge.
- R4: A delay of zero puts the sample cycle in the clock cycle right after the start edge.
- R5: A rising edge on ext_trig starts a conversion only while the trigger-enable bit (config bit 8) is 1. With that bit at 0, busy stays low.
- R6: A command start or a trigger edge that arrives while busy is high is ignored. The running conversion keeps its length and no second one follows.
- R7: Done rises on the same edge that busy falls, and the two are never high together. A read of address 3 returns the result in its low RES_W bits and clears done. A read of address 2 returns busy in bit 0 and done in bit 1.
- R8: irq equals done gated by the interrupt-enable bit (config bit 9).
- R9: With config bit 0 at 0 (single-ended), pos_ch equals the channel field (config bits 3:1), neg_ch is 0 and diff_en is 0.
- R10: With config bit 0 at 1 (differential), the pair index p is the low two bits of the channel field. pos_ch is 2p, neg_ch is 2p+1 and diff_en is 1.
- R11: ref_p_sel passes config bits 5:4 through unchanged (0 internal supply, 1 reference pin, 2 input 0, 3 input 3). ref_n_sel follows config bits 7:6 for codes 0 (internal supply), 1 (input 1) and 2 (input 2). Code 3 maps to 0.
- R12: ext_route follows config bit 10, the switch that sends the multiplexer output to the external filter pins.
- R13: A start accepted while done is still set clears done on the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 config, 1 delay, 2 command/status, 3 result |
| wdata | input | DW | Write data. A write to address 2 with bit 0 set is a start command |
| rdata | output | DW | Read data for addr |
| ext_trig | input | 1 | External start trigger, acts on its rising edge |
| cmp_in | input | 1 | Comparator result, 1 when the input is at or above dac_code |
| dac_code | output | RES_W | Trial code for the comparison DAC |
| sample | output | 1 | Sample strobe, one cycle per conversion |
| busy | output | 1 | Delay, sample or search in progress |
| done | output | 1 | Result ready, not yet read |
| irq | output | 1 | Completion interrupt |
| diff_en | output | 1 | Differential input selected |
| pos_ch | output | CH_W | Multiplexer positive input |
| neg_ch | output | CH_W | Multiplexer negative input |
| ref_p_sel | output | 2 | Positive reference source |
| ref_n_sel | output | 2 | Negative reference source |
| ext_route | output | 1 | Route multiplexer output to external pins |

## Verification
The bench builds the block with RES_W=8 and DLY_W=4. With that size every input level from 0 to 255 can be converted and compared with the ideal code, and all sixteen delay settings can be timed against the trigger edge in one short run. The eight channels in both modes and all sixteen reference code pairs are swept completely. Starts placed inside a running conversion and starts placed while done is still pending show that the one-shot sequencing holds.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_SAMPLE = 2'd2,
      ST_CONV   = 2'd3
   } seq_state_t;

   localparam logic [1:0] A_CFG = 2'd0;
   localparam logic [1:0] A_DLY = 2'd1;
   localparam logic [1:0] A_CMD = 2'd2;
   localparam logic [1:0] A_RES = 2'd3;

   localparam int CFG_W = 11;

   typedef struct packed {
      logic       route;
      logic       irq_en;
      logic       trig_en;
      logic [1:0] nref;
      logic [1:0] pref;
      logic [2:0] chan;
      logic       diff;
   } sar_cfg_t;

endpackage

// File: rtl/sar_cfg_regs.sv
module sar_cfg_regs
   import adc_sar_pkg::*;
#(
   parameter int DW    = 16,
   parameter int RES_W = 12,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic             busy,
   input  logic             fin,
   input  logic             start_acc,
   input  logic [RES_W-1:0] result,
   output sar_cfg_t         cfg,
   output logic [DLY_W-1:0] delay,
   output logic             sw_start,
   output logic             done
);

   logic rd_result;

   assign sw_start  = wr_en && (addr == A_CMD) && wdata[0];
   assign rd_result = rd_en && (addr == A_RES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg   <= '0;
         delay <= '0;
      end else if (wr_en) begin
         if (addr == A_CFG) cfg   <= sar_cfg_t'(wdata[CFG_W-1:0]);
         if (addr == A_DLY) delay <= wdata[DLY_W-1:0];
      end
   end

   // completion wins over a new start or a read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      done <= 1'b0;
      else if (fin)                    done <= 1'b1;
      else if (start_acc || rd_result) done <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_CFG: rdata[CFG_W-1:0] = cfg;
         A_DLY: rdata[DLY_W-1:0] = delay;
         A_CMD: rdata[1:0]       = {done, busy};
         A_RES: rdata[RES_W-1:0] = result;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
   import adc_sar_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_start,
   input  logic             ext_trig,
   input  logic             trig_en,
   input  logic [DLY_W-1:0] delay,
   input  logic             fin,
   output logic             start_acc,
   output logic             sample,
   output logic             busy
);

   seq_state_t       state_q;
   logic [DLY_W-1:0] cnt_q;
   logic             trig_q;
   logic             req;

   assign req       = sw_start || (trig_en && ext_trig && !trig_q);
   assign start_acc = req && (state_q == ST_IDLE);
   assign sample    = (state_q == ST_SAMPLE);
   assign busy      = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         trig_q  <= 1'b0;
      end else begin
         trig_q <= ext_trig;
         unique case (state_q)
            ST_IDLE: begin
               if (start_acc) begin
                  if (delay == '0) begin
                     state_q <= ST_SAMPLE;
                  end else begin
                     state_q <= ST_WAIT;
                     cnt_q   <= delay;
                  end
               end
            end
            ST_WAIT: begin
               if (cnt_q == DLY_W'(1)) state_q <= ST_SAMPLE;
               else                    cnt_q   <= cnt_q - 1'b1;
            end
            ST_SAMPLE: state_q <= ST_CONV;
            ST_CONV:   if (fin) state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sar_search.sv
module sar_search #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             cmp_in,
   output logic [RES_W-1:0] dac_code,
   output logic             fin,
   output logic [RES_W-1:0] result
);

   localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] ptr_q;
   logic [RES_W-1:0] acc_q;
   logic [RES_W-1:0] acc_nx;

   // the bit under test takes the comparator decision, settled bits hold
   for (genvar b = 0; b < RES_W; b++) begin : g_bit
      assign acc_nx[b] = ptr_q[b] ? cmp_in : acc_q[b];
   end

   assign dac_code = acc_q | ptr_q;
   assign fin      = ptr_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         acc_q  <= '0;
         result <= '0;
      end else if (load) begin
         ptr_q <= MSB_ONLY;
         acc_q <= '0;
      end else if (ptr_q != '0) begin
         ptr_q <= ptr_q >> 1;
         acc_q <= acc_nx;
         if (fin) result <= acc_nx;
      end
   end

endmodule

// File: rtl/sar_mux_map.sv
module sar_mux_map
   import adc_sar_pkg::*;
#(
   parameter int NUM_IN = 8,
   localparam int CH_W  = $clog2(NUM_IN)
) (
   input  sar_cfg_t        cfg,
   output logic            diff_en,
   output logic [CH_W-1:0] pos_ch,
   output logic [CH_W-1:0] neg_ch,
   output logic [1:0]      ref_p_sel,
   output logic [1:0]      ref_n_sel,
   output logic            ext_route
);

   logic [CH_W-1:0] d_pos;
   logic [CH_W-1:0] d_neg;

   if (CH_W > 1) begin : g_pairs
      assign d_pos = {cfg.chan[CH_W-2:0], 1'b0};
      assign d_neg = {cfg.chan[CH_W-2:0], 1'b1};
   end else begin : g_one_pair
      assign d_pos = 1'b0;
      assign d_neg = 1'b1;
   end

   assign diff_en   = cfg.diff;
   assign pos_ch    = cfg.diff ? d_pos : cfg.chan[CH_W-1:0];
   assign neg_ch    = cfg.diff ? d_neg : '0;
   assign ref_p_sel = cfg.pref;
   assign ref_n_sel = (cfg.nref == 2'd3) ? 2'd0 : cfg.nref;
   assign ext_route = cfg.route;

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
   import adc_sar_pkg::*;
#(
   parameter int DW     = 16,
   parameter int RES_W  = 12,
   parameter int DLY_W  = 8,
   parameter int NUM_IN = 8,
   localparam int CH_W  = $clog2(NUM_IN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic             ext_trig,
   input  logic             cmp_in,
   output logic [RES_W-1:0] dac_code,
   output logic             sample,
   output logic             busy,
   output logic             done,
   output logic             irq,
   output logic             diff_en,
   output logic [CH_W-1:0]  pos_ch,
   output logic [CH_W-1:0]  neg_ch,
   output logic [1:0]       ref_p_sel,
   output logic [1:0]       ref_n_sel,
   output logic             ext_route
);

   if (RES_W < 2 || RES_W > DW) begin : g_bad_res
      $error("RES_W must lie between 2 and DW");
   end
   if (DW < CFG_W || DLY_W > DW || DLY_W < 1) begin : g_bad_dw
      $error("DW too narrow for the config or delay field");
   end
   if (NUM_IN < 2 || NUM_IN > 8 || (1 << CH_W) != NUM_IN) begin : g_bad_in
      $error("NUM_IN must be 2, 4 or 8");
   end

   sar_cfg_t         cfg;
   logic [DLY_W-1:0] delay;
   logic             sw_start;
   logic             start_acc;
   logic             fin;
   logic [RES_W-1:0] res_w;

   sar_cfg_regs #(.DW(DW), .RES_W(RES_W), .DLY_W(DLY_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .busy      (busy),
      .fin       (fin),
      .start_acc (start_acc),
      .result    (res_w),
      .cfg       (cfg),
      .delay     (delay),
      .sw_start  (sw_start),
      .done      (done)
   );

   sar_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_start  (sw_start),
      .ext_trig  (ext_trig),
      .trig_en   (cfg.trig_en),
      .delay     (delay),
      .fin       (fin),
      .start_acc (start_acc),
      .sample    (sample),
      .busy      (busy)
   );

   sar_search #(.RES_W(RES_W)) u_search (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sample),
      .cmp_in   (cmp_in),
      .dac_code (dac_code),
      .fin      (fin),
      .result   (res_w)
   );

   sar_mux_map #(.NUM_IN(NUM_IN)) u_map (
      .cfg       (cfg),
      .diff_en   (diff_en),
      .pos_ch    (pos_ch),
      .neg_ch    (neg_ch),
      .ref_p_sel (ref_p_sel),
      .ref_n_sel (ref_n_sel),
      .ext_route (ext_route)
   );

   assign irq = done && cfg.irq_en;

endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
   parameter int RES_W = 12,
   parameter int DLY_W = 8,
   parameter int CH_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             irq,
   input logic             sample,
   input logic             diff_en,
   input logic [CH_W-1:0]  pos_ch,
   input logic [CH_W-1:0]  neg_ch,
   input logic [RES_W-1:0] dac_code,
   input logic [RES_W-1:0] result
);

   localparam int MAX_BUSY = (1 << DLY_W) + RES_W;
   localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   // R7
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R7
   done_on_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));

   // R3
   sample_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample |-> busy);

   // R3
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= MAX_BUSY);

   // R2
   msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sample) && busy) |-> (dac_code == MSB_ONLY));

   // R1
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(result));

   // R8
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);

   // R10
   diff_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      diff_en |-> (!pos_ch[0] && neg_ch == pos_ch + 1'b1));

endmodule

bind adc_sar_seq adc_sar_seq_chk #(.RES_W(RES_W), .DLY_W(DLY_W), .CH_W(CH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .irq      (irq),
   .sample   (sample),
   .diff_en  (diff_en),
   .pos_ch   (pos_ch),
   .neg_ch   (neg_ch),
   .dac_code (dac_code),
   .result   (res_w)
);

// File: tb/adc_sar_seq_bench.sv
module adc_sar_seq_bench;

   localparam int DW     = 16;
   localparam int RES_W  = 8;
   localparam int DLY_W  = 4;
   localparam int NUM_IN = 8;
   localparam int CH_W   = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             rd_en = 1'b0;
   logic [1:0]       addr = '0;
   logic [DW-1:0]    wdata = '0;
   logic [DW-1:0]    rdata;
   logic             ext_trig = 1'b0;
   logic             cmp_in;
   logic [RES_W-1:0] dac_code;
   logic             sample, busy, done, irq, diff_en, ext_route;
   logic [CH_W-1:0]  pos_ch, neg_ch;
   logic [1:0]       ref_p_sel, ref_n_sel;

   int vin = 0;
   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   // ideal comparator model
   assign cmp_in = (vin >= int'(dac_code));

   adc_sar_seq #(.DW(DW), .RES_W(RES_W), .DLY_W(DLY_W), .NUM_IN(NUM_IN)) u_adc_sar_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ext_trig(ext_trig), .cmp_in(cmp_in),
      .dac_code(dac_code), .sample(sample), .busy(busy), .done(done), .irq(irq),
      .diff_en(diff_en), .pos_ch(pos_ch), .neg_ch(neg_ch),
      .ref_p_sel(ref_p_sel), .ref_n_sel(ref_n_sel), .ext_route(ext_route)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] cfg_word(input int dif, input int ch, input int pr,
                                              input int nr, input int trg, input int ie,
                                              input int rt);
      logic [DW-1:0] w = '0;
      w[0]   = dif[0];
      w[3:1] = ch[2:0];
      w[5:4] = pr[1:0];
      w[7:6] = nr[1:0];
      w[8]   = trg[0];
      w[9]   = ie[0];
      w[10]  = rt[0];
      return w;
   endfunction

   task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // start a conversion and time it; poke >= 0 issues a second start mid-run
   task automatic do_conv(input int dly, input int level, input bit use_ext,
                          input int poke, input bit do_read, input string tag);
      int first_s = -1;
      int n_s = 0;
      int n_b = 0;
      int first_dac = -1;
      int k = 0;
      logic [DW-1:0] rv;
      vin = level;
      reg_write(2'd1, DW'(dly));
      if (use_ext) begin
         @(negedge clk); ext_trig = 1'b1;
         @(negedge clk); ext_trig = 1'b0;
      end else begin
         reg_write(2'd2, DW'(1));
      end
      // R13: start edge clears any pending done
      chk(done == 1'b0, "R13 done cleared by start", int'(done), 0);
      while (busy && k < 1000) begin
         if (sample) begin
            n_s++;
            if (first_s < 0) first_s = k;
         end
         if (k == dly + 1) first_dac = int'(dac_code);
         n_b++;
         if (k == poke) begin
            wr_en = 1'b1; addr = 2'd2; wdata = DW'(1); ext_trig = 1'b1;
         end else if (k == poke + 1) begin
            wr_en = 1'b0; wdata = '0; ext_trig = 1'b0;
         end
         k++;
         @(negedge clk);
      end
      wr_en = 1'b0; ext_trig = 1'b0;
      chk(n_b == dly + 1 + RES_W, {"R3 busy length ", tag}, n_b, dly + 1 + RES_W);
      chk(first_s == dly, {"R3 R4 sample position ", tag}, first_s, dly);
      chk(n_s == 1, {"R3 single sample ", tag}, n_s, 1);
      chk(first_dac == (1 << (RES_W - 1)), {"R2 first trial ", tag}, first_dac, 1 << (RES_W - 1));
      chk(done == 1'b1, {"R7 done at end ", tag}, int'(done), 1);
      if (poke >= 0) begin
         repeat (4) begin
            @(negedge clk);
            chk(busy == 1'b0, "R6 no restart after ignored start", int'(busy), 0);
         end
      end
      if (do_read) begin
         reg_read(2'd2, rv);
         chk(rv[1:0] == 2'b10, "R7 status reads done", int'(rv[1:0]), 2);
         reg_read(2'd3, rv);
         chk(int'(rv[RES_W-1:0]) == level, {"R1 result ", tag}, int'(rv[RES_W-1:0]), level);
         chk(done == 1'b0, "R7 result read clears done", int'(done), 0);
      end
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected end before 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(busy == 0 && done == 0 && sample == 0, "R7 reset idle", int'({busy, done, sample}), 0);
      chk(irq == 0, "R8 reset irq low", int'(irq), 0);
      reg_read(2'd2, rv);
      chk(rv == '0, "R7 reset status", int'(rv), 0);

      // every input level, command start, zero delay
      for (int v = 0; v < (1 << RES_W); v++) do_conv(0, v, 1'b0, -1, 1'b1, "sweep");

      // every delay, pin trigger enabled
      reg_write(2'd0, cfg_word(0, 0, 0, 0, 1, 0, 0));
      for (int d = 0; d < (1 << DLY_W); d++)
         do_conv(d, (d * 37 + 5) % (1 << RES_W), 1'b1, -1, 1'b1, "ext delay");

      // R5: trigger disabled, pin edge ignored
      reg_write(2'd0, cfg_word(0, 0, 0, 0, 0, 0, 0));
      @(negedge clk); ext_trig = 1'b1;
      @(negedge clk); ext_trig = 1'b0;
      begin
         int seen = 0;
         repeat (20) begin
            if (busy) seen++;
            @(negedge clk);
         end
         chk(seen == 0, "R5 trigger disabled ignored", seen, 0);
      end

      // R6: second starts inside a run, trigger enabled
      reg_write(2'd0, cfg_word(0, 0, 0, 0, 1, 0, 0));
      do_conv(6, 200, 1'b0, 3, 1'b1, "R6 start in delay");
      do_conv(2, 77, 1'b1, 8, 1'b1, "R6 start in search");

      // R13 and R8: new start while done pending, then irq gating
      do_conv(1, 10, 1'b0, -1, 1'b0, "R13 first");
      do_conv(0, 250, 1'b0, -1, 1'b0, "R13 second");
      chk(irq == 0, "R8 irq masked", int'(irq), 0);
      reg_write(2'd0, cfg_word(0, 0, 0, 0, 1, 1, 0));
      @(negedge clk);
      chk(irq == 1, "R8 irq with enable", int'(irq), 1);
      reg_read(2'd3, rv);
      chk(int'(rv[RES_W-1:0]) == 250, "R1 R13 result of second run", int'(rv[RES_W-1:0]), 250);
      chk(irq == 0, "R8 irq clears with done", int'(irq), 0);

      // R9 R10 R12: channel map in both modes
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < NUM_IN; c++) begin
            reg_write(2'd0, cfg_word(m, c, 0, 0, 0, 0, c % 2));
            if (m == 0) begin
               chk(pos_ch == c[2:0] && neg_ch == 0 && diff_en == 0, "R9 single map",
                   int'({diff_en, neg_ch, pos_ch}), c);
            end else begin
               chk(pos_ch == 3'(2 * (c % 4)) && neg_ch == 3'(2 * (c % 4) + 1) && diff_en == 1,
                   "R10 pair map", int'({diff_en, neg_ch, pos_ch}),
                   (1 << 6) | ((2 * (c % 4) + 1) << 3) | (2 * (c % 4)));
            end
            chk(ext_route == 1'(c % 2), "R12 route", int'(ext_route), c % 2);
         end
      end

      // R11: all reference code pairs
      for (int p = 0; p < 4; p++) begin
         for (int n = 0; n < 4; n++) begin
            reg_write(2'd0, cfg_word(0, 0, p, n, 0, 0, 0));
            chk(ref_p_sel == 2'(p), "R11 positive ref", int'(ref_p_sel), p);
            chk(ref_n_sel == 2'((n == 3) ? 0 : n), "R11 negative ref", int'(ref_n_sel),
                (n == 3) ? 0 : n);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule